// File: doc/BRIEF.md
# Cache Line Prefetch Controller

This block creates cache line-fill requests before the processor asks for those lines. In automatic mode it watches the stream of lookup results (hit or miss, with the line address). It reacts to the event kinds chosen by the trigger setting. When such an event falls inside one of two enabled address windows, it requests the neighbouring line in the configured direction. It never requests a line outside the window that the event fell in. In manual mode, software gives a start line, a line count and a direction. The block then walks that range one request per handshake, and raises a done flag when the last request has been accepted.

A manual run turns automatic prefetch off and records whether it was on. Ending the run turns it back on only if it was on before. A separate suspend/resume pair pauses automatic prefetch and leaves the configuration untouched. While the freeze control is set, no fill request leaves the block. Each miss event seen during freeze is answered one cycle later with a busy pulse or an error pulse, depending on the freeze mode. All addresses are line indices. Tag lookup and the fill datapath belong to neighbouring blocks.

Top module: `pfetch_ctrl`

## Requirements
- R1: After reset, fill_valid, man_done, frz_busy and frz_err are all 0, and automatic prefetch is off.
- R2: Control register (select 0) bits [2:1] pick the trigger: 0 reacts to misses only, 1 to hits only, 2 to both, 3 to neither. Bit 5 turns automatic prefetch on.
- R3: An event starts a prefetch only if its line lies in an enabled window. Window k uses enable bit 3+k of the control register, base at select 1+2k and size in lines at select 2+2k. The window covers base to base+size-1.
- R4: Control bit 0 picks the direction: 0 requests event line +1, 1 requests event line -1. The request appears on fill_valid/fill_line, with fill_src 0, in the cycle after the event.
- R5: No automatic request is made when the neighbouring line falls outside the event's window or would wrap the address.
- R6: A pending request keeps fill_valid and fill_line steady until fill_ready is seen. Triggers that arrive while a request is pending are dropped.
- R7: A man_start pulse loads start, count and direction. It latches the prior automatic-enable state on man_prev_auto and clears automatic enable. It then issues count requests (fill_src 1), one per accepted handshake, stepping +1 (man_dir 0) or -1 (man_dir 1).
- R8: man_done rises in the cycle after the last request is accepted, or right after a start with count 0. A man_end pulse clears man_done and turns automatic prefetch back on only if man_prev_auto is 1.
- R9: A pf_suspend pulse stops automatic triggers, and a pf_resume pulse restarts them. Neither changes the configuration.
- R10: While frz_en is 1, fill_valid is 0 and no event starts a prefetch. A request already pending reappears when freeze drops.
- R11: A miss event during freeze produces a one-cycle pulse in the next cycle: frz_busy when frz_mode is 0, frz_err when frz_mode is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 control, 1/2 window 0 base/size, 3/4 window 1 base/size |
| cfg_wdata | input | AW | Write data |
| ev_valid | input | 1 | Lookup event valid |
| ev_hit | input | 1 | 1 for hit, 0 for miss |
| ev_line | input | AW | Line address of the event |
| pf_suspend | input | 1 | Pause automatic prefetch |
| pf_resume | input | 1 | Restart automatic prefetch |
| man_start | input | 1 | Start a manual preload |
| man_line | input | AW | First line of the manual preload |
| man_cnt | input | CW | Number of lines to preload |
| man_dir | input | 1 | Manual direction: 0 up, 1 down |
| man_end | input | 1 | End the manual preload |
| man_done | output | 1 | Manual preload finished |
| man_prev_auto | output | 1 | Automatic enable state captured at start |
| frz_en | input | 1 | Freeze control |
| frz_mode | input | 1 | 0 busy answer, 1 error answer |
| frz_busy | output | 1 | Busy answer to a frozen miss |
| frz_err | output | 1 | Error answer to a frozen miss |
| fill_valid | output | 1 | Fill request valid |
| fill_ready | input | 1 | Fill request accepted |
| fill_line | output | AW | Requested line |
| fill_src | output | 1 | 0 automatic, 1 manual |

## Verification
An event, a configuration write or a man_start takes effect at the next rising edge. So a prefetch request, the frozen-miss pulses, man_prev_auto and the first manual line are all due one edge after the stimulus. Each manual step and the done flag are due one edge after the handshake that retires the previous line. The only combinational path is freeze gating fill_valid, which shows in the same cycle. The bench drives inputs 2 ns after a rising edge and samples at that same point after the next edge. Every check therefore reads the state that exactly one register stage has produced.

// File: rtl/pfetch_pkg.sv
`timescale 1ns/1ps
package pfetch_pkg;

    localparam int NUM_RGN = 2;

    typedef enum logic [1:0] {
        TRIG_MISS = 2'd0,
        TRIG_HIT  = 2'd1,
        TRIG_BOTH = 2'd2,
        TRIG_NONE = 2'd3
    } trig_e;

    // packed so that bit 0 = dir, [2:1] = trig, [4:3] = window enables, 5 = auto
    typedef struct packed {
        logic                auto_en;
        logic [NUM_RGN-1:0]  rgn_en;
        trig_e               trig;
        logic                dir;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [2:0] SEL_CTRL = 3'd0;

    function automatic logic trig_match(input trig_e t, input logic hit);
        case (t)
            TRIG_MISS: return !hit;
            TRIG_HIT:  return hit;
            TRIG_BOTH: return 1'b1;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pfetch_cfg.sv
`timescale 1ns/1ps
module pfetch_cfg
    import pfetch_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr,
    input  logic [2:0]                  sel,
    input  logic [AW-1:0]               wdata,
    input  logic                        man_go,
    input  logic                        man_stop,
    input  logic                        man_prev,
    output ctrl_t                       ctrl,
    output logic [NUM_RGN-1:0][AW-1:0]  base,
    output logic [NUM_RGN-1:0][AW-1:0]  size
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr && sel == SEL_CTRL) begin
            ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
        end else if (man_go) begin
            ctrl.auto_en <= 1'b0;
        end else if (man_stop && man_prev) begin
            ctrl.auto_en <= 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
        localparam logic [2:0] SEL_BASE = 3'(1 + 2 * g);
        localparam logic [2:0] SEL_SIZE = 3'(2 + 2 * g);
        always_ff @(posedge clk) begin
            if (rst) begin
                base[g] <= '0;
                size[g] <= '0;
            end else if (wr) begin
                if (sel == SEL_BASE) base[g] <= wdata;
                if (sel == SEL_SIZE) size[g] <= wdata;
            end
        end
    end

endmodule

// File: rtl/pfetch_region.sv
`timescale 1ns/1ps
module pfetch_region #(
    parameter int AW = 16
) (
    input  logic          en,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] size,
    input  logic [AW-1:0] cur_line,
    input  logic [AW-1:0] nxt_line,
    input  logic          nxt_wrap,
    output logic          cur_in,
    output logic          nxt_ok
);

    function automatic logic inside_win(input logic [AW-1:0] a,
                                        input logic [AW-1:0] b,
                                        input logic [AW-1:0] s);
        return (a >= b) && ((a - b) < s);
    endfunction

    assign cur_in = en && inside_win(cur_line, base, size);
    assign nxt_ok = en && !nxt_wrap && inside_win(nxt_line, base, size);

endmodule

// File: rtl/pfetch_auto.sv
`timescale 1ns/1ps
module pfetch_auto
    import pfetch_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  ctrl_t              ctrl,
    input  logic               suspend,
    input  logic               resume,
    input  logic               blocked,
    input  logic               flush,
    input  logic               ev_valid,
    input  logic               ev_hit,
    input  logic [NUM_RGN-1:0] rgn_in,
    input  logic [NUM_RGN-1:0] rgn_nxt_ok,
    input  logic [AW-1:0]      nxt_line,
    input  logic               take,
    output logic               pend,
    output logic [AW-1:0]      pend_line
);

    logic paused;
    logic nxt_fits;
    logic fire;

    // first window (lowest index) that holds the event decides the bound
    always_comb begin
        nxt_fits = 1'b0;
        for (int k = NUM_RGN - 1; k >= 0; k--) begin
            if (rgn_in[k]) nxt_fits = rgn_nxt_ok[k];
        end
    end

    assign fire = ev_valid && ctrl.auto_en && !paused && !blocked
               && trig_match(ctrl.trig, ev_hit) && nxt_fits;

    always_ff @(posedge clk) begin
        if (rst)          paused <= 1'b0;
        else if (suspend) paused <= 1'b1;
        else if (resume)  paused <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            pend_line <= '0;
        end else if (flush || take) begin
            pend <= 1'b0;
        end else if (!pend && fire) begin
            pend      <= 1'b1;
            pend_line <= nxt_line;
        end
    end

endmodule

// File: rtl/pfetch_manual.sv
`timescale 1ns/1ps
module pfetch_manual #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          stop,
    input  logic [AW-1:0] start_line,
    input  logic [CW-1:0] start_cnt,
    input  logic          start_dir,
    input  logic          auto_en,
    input  logic          take,
    output logic          busy,
    output logic          done,
    output logic          prev_auto,
    output logic [AW-1:0] line
);

    logic [CW-1:0] remain;
    logic          dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            prev_auto <= 1'b0;
            remain    <= '0;
            dir_q     <= 1'b0;
            line      <= '0;
        end else if (stop) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else if (go) begin
            prev_auto <= auto_en;
            line      <= start_line;
            dir_q     <= start_dir;
            remain    <= start_cnt;
            busy      <= (start_cnt != '0);
            done      <= (start_cnt == '0);
        end else if (busy && take) begin
            remain <= remain - 1'b1;
            line   <= dir_q ? line - 1'b1 : line + 1'b1;
            if (remain == CW'(1)) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pfetch_ctrl.sv
`timescale 1ns/1ps
module pfetch_ctrl
    import pfetch_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wr,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          ev_valid,
    input  logic          ev_hit,
    input  logic [AW-1:0] ev_line,
    input  logic          pf_suspend,
    input  logic          pf_resume,
    input  logic          man_start,
    input  logic [AW-1:0] man_line,
    input  logic [CW-1:0] man_cnt,
    input  logic          man_dir,
    input  logic          man_end,
    output logic          man_done,
    output logic          man_prev_auto,
    input  logic          frz_en,
    input  logic          frz_mode,
    output logic          frz_busy,
    output logic          frz_err,
    output logic          fill_valid,
    input  logic          fill_ready,
    output logic [AW-1:0] fill_line,
    output logic          fill_src
);

    ctrl_t                      ctrl;
    logic [NUM_RGN-1:0][AW-1:0] rgn_base;
    logic [NUM_RGN-1:0][AW-1:0] rgn_size;
    logic [NUM_RGN-1:0]         rgn_in;
    logic [NUM_RGN-1:0]         rgn_nxt_ok;
    logic [AW-1:0]              nxt_line;
    logic                       nxt_wrap;
    logic                       go;
    logic                       man_busy;
    logic [AW-1:0]              man_cur;
    logic                       auto_pend;
    logic [AW-1:0]              auto_line;
    logic                       take;

    // an end request in the same cycle wins over a start
    assign go = man_start && !man_end;

    assign nxt_line = ctrl.dir ? ev_line - 1'b1 : ev_line + 1'b1;
    assign nxt_wrap = ctrl.dir ? (ev_line == '0) : (&ev_line);

    pfetch_cfg #(.AW(AW)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr       (cfg_wr),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .man_go   (go),
        .man_stop (man_end),
        .man_prev (man_prev_auto),
        .ctrl     (ctrl),
        .base     (rgn_base),
        .size     (rgn_size)
    );

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_win
        pfetch_region #(.AW(AW)) u_win (
            .en       (ctrl.rgn_en[g]),
            .base     (rgn_base[g]),
            .size     (rgn_size[g]),
            .cur_line (ev_line),
            .nxt_line (nxt_line),
            .nxt_wrap (nxt_wrap),
            .cur_in   (rgn_in[g]),
            .nxt_ok   (rgn_nxt_ok[g])
        );
    end

    assign fill_valid = !frz_en && (man_busy || auto_pend);
    assign fill_line  = man_busy ? man_cur : auto_line;
    assign fill_src   = man_busy;
    assign take       = fill_valid && fill_ready;

    pfetch_auto #(.AW(AW)) u_auto (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl),
        .suspend    (pf_suspend),
        .resume     (pf_resume),
        .blocked    (frz_en || man_busy),
        .flush      (go),
        .ev_valid   (ev_valid),
        .ev_hit     (ev_hit),
        .rgn_in     (rgn_in),
        .rgn_nxt_ok (rgn_nxt_ok),
        .nxt_line   (nxt_line),
        .take       (take && !man_busy),
        .pend       (auto_pend),
        .pend_line  (auto_line)
    );

    pfetch_manual #(.AW(AW), .CW(CW)) u_man (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .stop       (man_end),
        .start_line (man_line),
        .start_cnt  (man_cnt),
        .start_dir  (man_dir),
        .auto_en    (ctrl.auto_en),
        .take       (take && man_busy),
        .busy       (man_busy),
        .done       (man_done),
        .prev_auto  (man_prev_auto),
        .line       (man_cur)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            frz_busy <= 1'b0;
            frz_err  <= 1'b0;
        end else begin
            frz_busy <= ev_valid && !ev_hit && frz_en && !frz_mode;
            frz_err  <= ev_valid && !ev_hit && frz_en &&  frz_mode;
        end
    end

endmodule

// File: rtl/pfetch_chk.sv
`timescale 1ns/1ps
module pfetch_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          ev_valid,
    input logic          ev_hit,
    input logic          man_start,
    input logic          man_end,
    input logic          man_done,
    input logic          frz_en,
    input logic          frz_mode,
    input logic          frz_busy,
    input logic          frz_err,
    input logic          fill_valid,
    input logic          fill_ready,
    input logic [AW-1:0] fill_line,
    input logic          fill_src
);

    p_held_r6: assert property (@(posedge clk) disable iff (rst)
        fill_valid && !fill_ready && !man_start && !man_end
        |=> (fill_valid || frz_en) && $stable(fill_line));

    p_frozen_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        frz_en |-> !fill_valid);

    p_busy_answer_r11: assert property (@(posedge clk) disable iff (rst)
        ev_valid && !ev_hit && frz_en && !frz_mode |=> frz_busy && !frz_err);

    p_err_answer_r11: assert property (@(posedge clk) disable iff (rst)
        ev_valid && !ev_hit && frz_en && frz_mode |=> frz_err && !frz_busy);

    p_no_answer_r11: assert property (@(posedge clk) disable iff (rst)
        !(ev_valid && !ev_hit && frz_en) |=> !frz_busy && !frz_err);

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        man_done |-> !(fill_valid && fill_src));

    p_start_owns_r7: assert property (@(posedge clk) disable iff (rst)
        man_start && !man_end |=> !fill_valid || fill_src);

endmodule

bind pfetch_ctrl pfetch_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ev_valid   (ev_valid),
    .ev_hit     (ev_hit),
    .man_start  (man_start),
    .man_end    (man_end),
    .man_done   (man_done),
    .frz_en     (frz_en),
    .frz_mode   (frz_mode),
    .frz_busy   (frz_busy),
    .frz_err    (frz_err),
    .fill_valid (fill_valid),
    .fill_ready (fill_ready),
    .fill_line  (fill_line),
    .fill_src   (fill_src)
);

// File: tb/pfetch_ctrl_tb.sv
`timescale 1ns/1ps
module pfetch_ctrl_tb;

    localparam int AW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          ev_valid = 1'b0;
    logic          ev_hit = 1'b0;
    logic [AW-1:0] ev_line = '0;
    logic          pf_suspend = 1'b0;
    logic          pf_resume = 1'b0;
    logic          man_start = 1'b0;
    logic [AW-1:0] man_line = '0;
    logic [CW-1:0] man_cnt = '0;
    logic          man_dir = 1'b0;
    logic          man_end = 1'b0;
    logic          man_done;
    logic          man_prev_auto;
    logic          frz_en = 1'b0;
    logic          frz_mode = 1'b0;
    logic          frz_busy;
    logic          frz_err;
    logic          fill_valid;
    logic          fill_ready = 1'b0;
    logic [AW-1:0] fill_line;
    logic          fill_src;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #4 clk = ~clk;

    pfetch_ctrl #(.AW(AW), .CW(CW)) u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ev_valid(ev_valid), .ev_hit(ev_hit), .ev_line(ev_line),
        .pf_suspend(pf_suspend), .pf_resume(pf_resume),
        .man_start(man_start), .man_line(man_line), .man_cnt(man_cnt), .man_dir(man_dir),
        .man_end(man_end), .man_done(man_done), .man_prev_auto(man_prev_auto),
        .frz_en(frz_en), .frz_mode(frz_mode), .frz_busy(frz_busy), .frz_err(frz_err),
        .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_line(fill_line), .fill_src(fill_src)
    );

    // control word: dir | trig<<1 | en0<<3 | en1<<4 | auto<<5
    function automatic logic [AW-1:0] ctl(input int dir, input int trig, input int en0,
                                          input int en1, input int auto_on);
        return AW'(dir | (trig << 1) | (en0 << 3) | (en1 << 4) | (auto_on << 5));
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input logic [AW-1:0] d);
        cfg_wr = 1'b1; cfg_sel = 3'(sel); cfg_wdata = d;
        step();
        cfg_wr = 1'b0;
    endtask

    task automatic ev(input logic hit, input int line);
        ev_valid = 1'b1; ev_hit = hit; ev_line = AW'(line);
        step();
        ev_valid = 1'b0;
    endtask

    task automatic accept();
        fill_ready = 1'b1;
        step();
        fill_ready = 1'b0;
    endtask

    task automatic expect_req(input string req, input int line, input int src);
        chk(req, 32'(fill_valid), 32'd1);
        chk(req, 32'(fill_line), 32'(line));
        chk(req, 32'(fill_src), 32'(src));
        accept();
        chk(req, 32'(fill_valid), 32'd0);
    endtask

    task automatic mstart(input int line, input int cnt, input logic dir);
        man_start = 1'b1; man_line = AW'(line); man_cnt = CW'(cnt); man_dir = dir;
        step();
        man_start = 1'b0;
    endtask

    task automatic mend();
        man_end = 1'b1;
        step();
        man_end = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 valid", 32'(fill_valid), 0);
        chk("R1 done", 32'(man_done), 0);
        chk("R1 busy", 32'(frz_busy), 0);
        chk("R1 err", 32'(frz_err), 0);
        wr(1, 16'd100); wr(2, 16'd8); wr(3, 16'd200); wr(4, 16'd4);
        ev(1'b0, 103);
        chk("R1 auto off after reset", 32'(fill_valid), 0);
    endtask

    task automatic t_direction();
        wr(0, ctl(0, 0, 1, 1, 1));
        ev(1'b0, 103);
        expect_req("R4 upward", 104, 0);
        wr(0, ctl(1, 0, 1, 1, 1));
        ev(1'b0, 103);
        expect_req("R4 downward", 102, 0);
    endtask

    task automatic t_trigger();
        wr(0, ctl(0, 0, 1, 1, 1));
        ev(1'b1, 103);
        chk("R2 miss-only ignores hit", 32'(fill_valid), 0);
        wr(0, ctl(0, 1, 1, 1, 1));
        ev(1'b0, 103);
        chk("R2 hit-only ignores miss", 32'(fill_valid), 0);
        ev(1'b1, 103);
        expect_req("R2 hit-only hit", 104, 0);
        wr(0, ctl(0, 2, 1, 1, 1));
        ev(1'b1, 102);
        expect_req("R2 both hit", 103, 0);
        ev(1'b0, 104);
        expect_req("R2 both miss", 105, 0);
        wr(0, ctl(0, 3, 1, 1, 1));
        ev(1'b0, 103);
        chk("R2 code 3 miss", 32'(fill_valid), 0);
        ev(1'b1, 103);
        chk("R2 code 3 hit", 32'(fill_valid), 0);
    endtask

    task automatic t_region();
        wr(0, ctl(0, 0, 1, 1, 1));
        ev(1'b0, 150);
        chk("R3 outside windows", 32'(fill_valid), 0);
        ev(1'b0, 201);
        expect_req("R3 window 1", 202, 0);
        wr(0, ctl(0, 0, 1, 0, 1));
        ev(1'b0, 201);
        chk("R3 disabled window", 32'(fill_valid), 0);
    endtask

    task automatic t_bounds();
        wr(0, ctl(0, 0, 1, 1, 1));
        ev(1'b0, 107);
        chk("R5 top edge", 32'(fill_valid), 0);
        ev(1'b0, 106);
        expect_req("R5 last inner line", 107, 0);
        wr(0, ctl(1, 0, 1, 1, 1));
        ev(1'b0, 100);
        chk("R5 bottom edge", 32'(fill_valid), 0);
        ev(1'b0, 200);
        chk("R5 bottom edge window 1", 32'(fill_valid), 0);
    endtask

    task automatic t_hold();
        wr(0, ctl(0, 0, 1, 1, 1));
        ev(1'b0, 103);
        step(); step();
        chk("R6 still valid", 32'(fill_valid), 1);
        chk("R6 line steady", 32'(fill_line), 104);
        ev(1'b0, 105);
        chk("R6 second trigger ignored", 32'(fill_line), 104);
        accept();
        chk("R6 dropped trigger", 32'(fill_valid), 0);
    endtask

    task automatic t_suspend();
        pf_suspend = 1'b1; step(); pf_suspend = 1'b0;
        ev(1'b0, 103);
        chk("R9 suspended", 32'(fill_valid), 0);
        pf_resume = 1'b1; step(); pf_resume = 1'b0;
        ev(1'b0, 103);
        expect_req("R9 resumed keeps config", 104, 0);
    endtask

    task automatic t_freeze();
        frz_en = 1'b1; frz_mode = 1'b0;
        ev(1'b0, 103);
        chk("R11 busy pulse", 32'(frz_busy), 1);
        chk("R11 no err in mode 0", 32'(frz_err), 0);
        chk("R10 no request frozen", 32'(fill_valid), 0);
        step();
        chk("R11 busy one cycle", 32'(frz_busy), 0);
        frz_mode = 1'b1;
        ev(1'b0, 103);
        chk("R11 err pulse", 32'(frz_err), 1);
        chk("R11 no busy in mode 1", 32'(frz_busy), 0);
        frz_en = 1'b0;
        step();
        chk("R10 frozen miss not kept", 32'(fill_valid), 0);
        ev(1'b0, 103);
        chk("R10 pending before freeze", 32'(fill_valid), 1);
        frz_en = 1'b1;
        step();
        chk("R10 masked", 32'(fill_valid), 0);
        frz_en = 1'b0;
        step();
        expect_req("R10 pending reappears", 104, 0);
    endtask

    task automatic t_manual();
        wr(0, ctl(0, 0, 1, 1, 1));
        mstart(50, 3, 1'b0);
        chk("R7 prev auto on", 32'(man_prev_auto), 1);
        chk("R7 first line", 32'(fill_line), 50);
        chk("R7 manual source", 32'(fill_src), 1);
        chk("R7 valid", 32'(fill_valid), 1);
        fill_ready = 1'b1;
        step();
        chk("R7 second line", 32'(fill_line), 51);
        step();
        chk("R7 third line", 32'(fill_line), 52);
        chk("R8 not done early", 32'(man_done), 0);
        step();
        fill_ready = 1'b0;
        chk("R8 done", 32'(man_done), 1);
        chk("R8 no request when done", 32'(fill_valid), 0);
        ev(1'b0, 103);
        chk("R7 auto suspended", 32'(fill_valid), 0);
        mend();
        chk("R8 end clears done", 32'(man_done), 0);
        ev(1'b0, 103);
        expect_req("R8 auto restored", 104, 0);

        wr(0, ctl(0, 0, 1, 1, 0));
        mstart(60, 2, 1'b1);
        chk("R7 prev auto off", 32'(man_prev_auto), 0);
        chk("R7 down first", 32'(fill_line), 60);
        fill_ready = 1'b1;
        step();
        chk("R7 down second", 32'(fill_line), 59);
        step();
        fill_ready = 1'b0;
        chk("R8 done down", 32'(man_done), 1);
        mend();
        ev(1'b0, 103);
        chk("R8 auto stays off", 32'(fill_valid), 0);

        mstart(70, 0, 1'b0);
        chk("R8 zero count done", 32'(man_done), 1);
        chk("R8 zero count no request", 32'(fill_valid), 0);
        mend();
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        step(); step();
        rst = 1'b0;
        step();
        t_reset();
        t_direction();
        t_trigger();
        t_region();
        t_bounds();
        t_hold();
        t_suspend();
        t_freeze();
        t_manual();
        finish_run();
    end

endmodule